// File: doc/BRIEF.md
# Coprocessor-Attached Sequential Multiplier

This block sits beside a CPU on a coprocessor handshake. The CPU offers it an instruction word and two 32-bit source operands. The unit checks whether the instruction is one of the four 32-bit multiply forms: the low-half product, or the high half with signed×signed, signed×unsigned or unsigned×unsigned operands. If it is not, the unit stays silent. If it is, the unit claims the request by raising a wait flag on the next clock.

The product is formed one bit per clock by a shift-and-add loop over 2·XLEN-bit operands. Each operand is sign- or zero-extended to that width as the form requires. The low-half form needs only XLEN iterations, while the high-half forms need 2·XLEN. When the loop ends, the unit pulses ready and write-enable for one clock, with the selected half of the product on the result bus. The unit is idle again on the following clock. If the CPU withdraws the request before the result is ready, the computation is abandoned.

The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `cop_seq_mul`

## Requirements
- R1: A request is accepted only when the instruction has bits [6:0] = 0110011, bits [31:25] = 0000001 and bits [14:12] in the range 000 to 011. Any other instruction, held valid for any time, produces no wait, ready or write pulse.
- R2: Wait goes high on the clock after the edge that samples valid with an accepted instruction while the unit is idle. It stays high until the cycle in which ready is high.
- R3: Function 000 returns the low 32 bits of rs1·rs2.
- R4: Function 001 returns the high 32 bits of the product of two signed operands.
- R5: Function 010 returns the high 32 bits of signed rs1 times unsigned rs2.
- R6: Function 011 returns the high 32 bits of the product of two unsigned operands.
- R7: Ready rises on the 33rd rising edge after the accepting edge for function 000, and on the 65th for functions 001 to 011.
- R8: Ready and write-enable are high together for exactly one cycle, and wait is low in that cycle.
- R9: Wait is low in the cycle after ready. A request presented from that cycle onward is accepted at the next edge.
- R10: If valid is low at an edge while wait is high, the unit returns to idle. It raises neither ready nor write-enable for that request.
- R11: While reset is asserted, and in the first cycles after it is released, wait, ready and write-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_valid_i | input | 1 | CPU offers an instruction |
| cop_insn_i | input | 32 | Instruction word |
| cop_rs1_i | input | 32 | First source operand |
| cop_rs2_i | input | 32 | Second source operand |
| cop_wr_o | output | 1 | Result write-enable pulse |
| cop_rd_o | output | 32 | Result, meaningful while ready is high |
| cop_wait_o | output | 1 | Request claimed and in progress |
| cop_ready_o | output | 1 | Completion pulse |

## Verification
A corrupted step counter appears at the ports as ready arriving one or more edges early or late. The bench catches this on the very cycle that wait and ready disagree with the reference. A wrong extension choice or a stuck accumulator bit shows up only at completion, as a result mismatch on the single ready cycle; negative and all-ones operands are used so that high-half errors cannot hide. A state register that fails to clear on abort shows up as a ready pulse in a cycle where the reference expects the unit to be idle.

// File: rtl/cop_mul_pkg.sv
package cop_mul_pkg;
  localparam logic [6:0] OPC_REG_OP = 7'b0110011;
  localparam logic [6:0] F7_MULDIV  = 7'b0000001;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} mul_state_e;

  typedef struct packed {
    logic hi;          // return upper half
    logic rs1_signed;
    logic rs2_signed;
  } mul_kind_t;
endpackage

// File: rtl/cop_mul_decode.sv
module cop_mul_decode
  import cop_mul_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        match_o,
  output mul_kind_t   kind_o
);
  logic [2:0] fn;
  assign fn = insn_i[14:12];

  always_comb begin
    match_o = (insn_i[6:0] == OPC_REG_OP) && (insn_i[31:25] == F7_MULDIV) && !fn[2];
    kind_o.hi         = (fn[1:0] != 2'b00);
    kind_o.rs1_signed = (fn[1:0] == 2'b01) || (fn[1:0] == 2'b10);
    kind_o.rs2_signed = (fn[1:0] == 2'b01);
  end
endmodule

// File: rtl/cop_mul_ctrl.sv
module cop_mul_ctrl
  import cop_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid_i,
  input  logic      match_i,
  input  mul_kind_t kind_i,
  output logic      load_o,
  output logic      step_o,
  output logic      wait_o,
  output logic      ready_o
);
  localparam int CW = $clog2(2*XLEN + 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (valid_i && match_i) begin
          state_d = ST_BUSY;
          cnt_d   = kind_i.hi ? CW'(2*XLEN) : CW'(XLEN);
          load_o  = 1'b1;
        end
      end
      ST_BUSY: begin
        if (!valid_i) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          step_o = 1'b1;
          cnt_d  = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wait_o  = (state_q == ST_BUSY);
  assign ready_o = (state_q == ST_DONE);

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
  a_r9_idle_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !wait_o);
  a_r2_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && valid_i) |=> (wait_o || ready_o));
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !valid_i) |=> (!wait_o && !ready_o));
  a_r1_claim_decoded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |-> ($past(match_i) && $past(valid_i)));
endmodule

// File: rtl/cop_mul_datapath.sv
module cop_mul_datapath
  import cop_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  mul_kind_t       kind_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] rd_o
);
  localparam int PW = 2*XLEN;

  logic [PW-1:0] acc_q, acc_d, mcand_q, mcand_d, mplier_q, mplier_d;
  logic          hi_q, hi_d;
  logic          en;

  assign en = load_i | step_i;

  always_comb begin
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    hi_d     = hi_q;
    if (load_i) begin
      acc_d    = '0;
      mcand_d  = {{XLEN{kind_i.rs1_signed & rs1_i[XLEN-1]}}, rs1_i};
      mplier_d = {{XLEN{kind_i.rs2_signed & rs2_i[XLEN-1]}}, rs2_i};
      hi_d     = kind_i.hi;
    end else if (step_i) begin
      acc_d    = mplier_q[0] ? (acc_q + mcand_q) : acc_q;
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      hi_q     <= 1'b0;
    end else if (en) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      hi_q     <= hi_d;
    end
  end

  assign rd_o = hi_q ? acc_q[PW-1:XLEN] : acc_q[XLEN-1:0];

  a_r7_no_load_during_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && step_i));
  a_r3_multiplier_drains: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (mplier_q[PW-1] == 1'b0));
endmodule

// File: rtl/cop_seq_mul.sv
module cop_seq_mul
  import cop_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cop_valid_i,
  input  logic [31:0]     cop_insn_i,
  input  logic [XLEN-1:0] cop_rs1_i,
  input  logic [XLEN-1:0] cop_rs2_i,
  output logic            cop_wr_o,
  output logic [XLEN-1:0] cop_rd_o,
  output logic            cop_wait_o,
  output logic            cop_ready_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       match, load, step;
  mul_kind_t  kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cop_mul_decode u_dec (
    .insn_i  (cop_insn_i),
    .match_o (match),
    .kind_o  (kind)
  );

  cop_mul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .valid_i (cop_valid_i),
    .match_i (match),
    .kind_i  (kind),
    .load_o  (load),
    .step_o  (step),
    .wait_o  (cop_wait_o),
    .ready_o (cop_ready_o)
  );

  cop_mul_datapath #(.XLEN(XLEN)) u_dp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .step_i (step),
    .kind_i (kind),
    .rs1_i  (cop_rs1_i),
    .rs2_i  (cop_rs2_i),
    .rd_o   (cop_rd_o)
  );

  assign cop_wr_o = cop_ready_o;

  a_r11_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!cop_wait_o && !cop_ready_o && !cop_wr_o));
endmodule

// File: tb/test_cop_seq_mul.sv
`timescale 1ns/1ps
module test_cop_seq_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [31:0] insn, rs1, rs2;
  logic        wr, wt, rdy;
  logic [31:0] rd;

  int checks = 0;
  int fails  = 0;

  // reference model state: 0 idle, 1 busy, 2 done
  int          m_state = 0;
  int          m_cnt   = 0;
  logic [31:0] m_exp;
  int          m_fn;

  always #2 clk = ~clk;

  cop_seq_mul i_cop_seq_mul (
    .clk(clk), .rst_n(rst_n), .cop_valid_i(valid), .cop_insn_i(insn),
    .cop_rs1_i(rs1), .cop_rs2_i(rs2), .cop_wr_o(wr), .cop_rd_o(rd),
    .cop_wait_o(wt), .cop_ready_o(rdy)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic bit accepted(input logic [31:0] w);
    return (w[6:0] == 7'b0110011) && (w[31:25] == 7'b0000001) && (w[14:12] <= 3'd3);
  endfunction

  function automatic logic [31:0] ref_result(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = {32'd0, a};
    eb = {32'd0, b};
    if (f == 3'd1 || f == 3'd2) ea = {{32{a[31]}}, a};
    if (f == 3'd1)              eb = {{32{b[31]}}, b};
    p = ea * eb;
    return (f == 3'd0) ? p[31:0] : p[63:32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    case (m_state)
      0: if (valid && accepted(insn)) begin
           m_state = 1;
           m_fn    = int'(insn[14:12]);
           m_cnt   = (insn[14:12] == 3'd0) ? 32 : 64;
           m_exp   = ref_result(insn[14:12], rs1, rs2);
         end
      1: if (!valid) m_state = 0;
         else if (m_cnt == 0) m_state = 2;
         else m_cnt--;
      default: m_state = 0;
    endcase
    @(negedge clk);
    check(wt == (m_state == 1), "R2/R10 wait", {31'd0, wt}, {31'd0, m_state == 1});
    check(rdy == (m_state == 2), "R8/R9 ready", {31'd0, rdy}, {31'd0, m_state == 2});
    check(wr == (m_state == 2), "R8 wr", {31'd0, wr}, {31'd0, m_state == 2});
    if (m_state == 2 && rdy) begin
      case (m_fn)
        0: check(rd == m_exp, "R3 MUL result", rd, m_exp);
        1: check(rd == m_exp, "R4 MULH result", rd, m_exp);
        2: check(rd == m_exp, "R5 MULHSU result", rd, m_exp);
        default: check(rd == m_exp, "R6 MULHU result", rd, m_exp);
      endcase
    end
  endtask

  // run one request; abort_at > 0 drops valid after that many edges
  task automatic run_op(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b, input int abort_at);
    int exp_lat;
    exp_lat = (w[14:12] == 3'd0) ? 34 : 66;
    insn = w; rs1 = a; rs2 = b; valid = 1'b1;
    for (int n = 1; n <= 100; n++) begin
      step();
      if (rdy) begin
        check(n == exp_lat, "R7 latency", n, exp_lat);
        valid = 1'b0;
        step();
        return;
      end
      if (n == abort_at) begin
        valid = 1'b0;
        step(); step();
        return;
      end
    end
    check(0, "R7 no completion", 32'd0, 32'd1);
    valid = 1'b0;
    step();
  endtask

  task automatic run_ignored(input logic [31:0] w);
    insn = w; rs1 = 32'h1234; rs2 = 32'h5678; valid = 1'b1;
    for (int n = 0; n < 80; n++) begin
      step();
      check(!wt && !rdy && !wr, "R1 ignored insn", {29'd0, wt, rdy, wr}, 32'd0);
    end
    valid = 1'b0;
    step();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; insn = '0; rs1 = '0; rs2 = '0;
    repeat (3) @(negedge clk);
    check(!wt && !rdy && !wr, "R11 reset outputs", {29'd0, wt, rdy, wr}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check(!wt && !rdy, "R11 after release", {30'd0, wt, rdy}, 32'd0);
    end

    // R3 low half
    run_op(mk(7'h01, 3'd0, 7'h33), 32'd7, 32'd9, 0);
    run_op(mk(7'h01, 3'd0, 7'h33), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op(mk(7'h01, 3'd0, 7'h33), 32'h8000_0001, 32'h7FFF_FFFF, 0);
    // R4 signed high
    run_op(mk(7'h01, 3'd1, 7'h33), 32'hFFFF_FFFE, 32'd3, 0);
    run_op(mk(7'h01, 3'd1, 7'h33), 32'h8000_0000, 32'h8000_0000, 0);
    // R5 signed x unsigned high
    run_op(mk(7'h01, 3'd2, 7'h33), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op(mk(7'h01, 3'd2, 7'h33), 32'h1234_5678, 32'h9ABC_DEF0, 0);
    // R6 unsigned high
    run_op(mk(7'h01, 3'd3, 7'h33), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op(mk(7'h01, 3'd3, 7'h33), 32'hDEAD_BEEF, 32'h0000_0000, 0);
    // R1 non-multiply instructions
    run_ignored(mk(7'h00, 3'd0, 7'h33));
    run_ignored(mk(7'h01, 3'd4, 7'h33));
    run_ignored(mk(7'h01, 3'd0, 7'h13));
    // R10 abort during run, then R9 fresh request right after
    run_op(mk(7'h01, 3'd1, 7'h33), 32'd5, 32'd6, 10);
    run_op(mk(7'h01, 3'd0, 7'h33), 32'd100, 32'd200, 0);
    run_op(mk(7'h01, 3'd3, 7'h33), 32'hC000_0000, 32'h0000_0004, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule